// File: doc/BRIEF.md
# Duplex-Aware FIFO DMA Request Generator

This block decides when a MAC's transmit and receive FIFOs should ask the bus master for a DMA transfer. It watches the fill level of each FIFO, a 2-bit watermark select per direction, the progress of the current transmit and receive frames, and the end-of-frame strobes from the frame checker. It drives one registered request line per direction.

In half-duplex operation a shared medium can still produce a collision early in a frame, so two hold rules apply. On the receive side no transfer starts until the current frame has delivered 64 bytes. On the transmit side the bytes of the frame already sent still take up FIFO space until 64 of them have gone out, so that a retry can be made from the FIFO. In full-duplex operation both rules are dropped. A runt-accept override gives the full-duplex receive behaviour while the link is still in half duplex.

Top module: `duplex_dma_request`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `txReq` and `rxReq` are low, whatever the inputs are.
- R2: Watermark code 0 selects 16 bytes, code 1 selects 64, code 2 selects 128 and code 3 selects 256. This applies to both `txWmSel` and `rxWmSel`.
- R3: `txReq` is high exactly when, on the previous clock edge, the transmit free space was at least the transmit watermark. Free space is `FIFO_DEPTH` minus `txFifoLevel` minus any retained bytes, with a floor of 0.
- R4: In half duplex, while `txActive` is high and `txSentBytes` is below 64, the `txSentBytes` bytes already sent count as occupied space.
- R5: In full duplex, bytes already sent never count as occupied. The transmit watermark alone decides.
- R6: In half duplex, with the override low, the receive watermark raises `rxReq` only after 64 byte strobes (`rxByteIn`) of the current frame.
- R7: In full duplex, `rxReq` follows the receive watermark (`rxFifoLevel` at or above it) one cycle later, whatever the frame's length.
- R8: In half duplex with `runtAccept` high, receive requests behave exactly as in full duplex.
- R9: An `rxFrameDone` pulse holds `rxReq` high from the next cycle until `rxFifoLevel` reaches 0, whatever the watermark. In half duplex without the override, this only happens if the frame counted 64 bytes and was not killed.
- R10: `rxSof` restarts the byte count of the frame. A byte strobe in the same cycle is counted as the frame's first byte. The half-duplex receive gate closes again.
- R11: In half duplex, an `rxFrameBad` pulse that arrives before 64 bytes blocks every receive request for that frame. A pulse that arrives after 64 bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fullDuplex | input | 1 | 1 = full-duplex link |
| runtAccept | input | 1 | Half-duplex override that gives full-duplex receive rules |
| txWmSel | input | 2 | Transmit free-space watermark code |
| rxWmSel | input | 2 | Receive stored-bytes watermark code |
| txFifoLevel | input | LVL_W | Bytes stored in transmit FIFO |
| rxFifoLevel | input | LVL_W | Bytes stored in receive FIFO |
| txActive | input | 1 | A transmit frame is on the wire |
| txSentBytes | input | SENT_W | Bytes of current transmit frame sent |
| rxSof | input | 1 | Start-of-frame strobe, receive |
| rxByteIn | input | 1 | One received byte written this cycle |
| rxFrameBad | input | 1 | Current receive frame marked invalid |
| rxFrameDone | input | 1 | Complete valid receive frame stored |
| txReq | output | 1 | Transmit DMA request |
| rxReq | output | 1 | Receive DMA request |

## Verification
A receive byte counter that is off by one moves the rising edge of `rxReq` by one cycle around the 64th byte strobe. This shows up at once, because each cycle's output is compared with a reference. A stuck kill or pending flag shows up as a request that is missing or that stays high after the FIFO level returns to zero, within two cycles of the causing input. A wrong retention term or threshold decode makes `txReq` differ at the exact boundary levels, one cycle after they are applied.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int WM_W = 9;

  typedef struct packed {
    logic rxEligible;
    logic rxDonePending;
    logic txRetain;
  } ctlStrobes_t;

  function automatic logic [WM_W-1:0] wmBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 9'd16;
      2'd1:    return 9'd64;
      2'd2:    return 9'd128;
      default: return 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int RUNT_BYTES = 64,
  parameter int SENT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fullDuplex,
  input  logic              runtAccept,
  input  logic              rxSof,
  input  logic              rxByteIn,
  input  logic              rxFrameBad,
  input  logic              rxFrameDone,
  input  logic              rxDrained,
  input  logic              txActive,
  input  logic [SENT_W-1:0] txSentBytes,
  output ctlStrobes_t       strobes
);
  localparam int CNT_W = $clog2(RUNT_BYTES + 1);

  logic [CNT_W-1:0] rxCount;
  logic             rxKilled;
  logic             rxPending;
  logic             relaxed;
  logic             minReached;
  logic             gateOpen;

  assign relaxed    = fullDuplex | runtAccept;
  assign minReached = (rxCount == CNT_W'(RUNT_BYTES));
  assign gateOpen   = minReached & ~rxKilled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxCount   <= '0;
      rxKilled  <= 1'b0;
      rxPending <= 1'b0;
    end else begin
      if (rxSof) begin
        rxCount  <= rxByteIn ? CNT_W'(1) : '0;
        rxKilled <= 1'b0;
      end else begin
        if (rxByteIn && !minReached) rxCount <= rxCount + 1'b1;
        if (rxFrameBad && !minReached) rxKilled <= 1'b1;
      end
      if (rxFrameDone && (relaxed || gateOpen)) rxPending <= 1'b1;
      else if (rxDrained)                       rxPending <= 1'b0;
    end
  end

  always_comb begin
    strobes.rxEligible    = relaxed | gateOpen;
    strobes.rxDonePending = rxPending;
    strobes.txRetain      = ~fullDuplex & txActive &
                            (txSentBytes < SENT_W'(RUNT_BYTES));
  end

  AST_SOF_CLEARS_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    rxSof |=> !rxKilled); // R10
  AST_SOF_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rxSof |=> (rxCount <= CNT_W'(1))); // R10
  AST_LATE_BAD_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxSof && !rxKilled && minReached) |=> !rxKilled); // R11
  AST_FULL_NO_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
    fullDuplex |-> !strobes.txRetain); // R5

endmodule

// File: rtl/dma_req_path.sv
module dma_req_path
  import dma_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int RUNT_BYTES = 64,
  parameter int SENT_W     = 11,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        txWmSel,
  input  logic [1:0]        rxWmSel,
  input  logic [LVL_W-1:0]  txFifoLevel,
  input  logic [LVL_W-1:0]  rxFifoLevel,
  input  logic [SENT_W-1:0] txSentBytes,
  input  ctlStrobes_t       strobes,
  output logic              rxDrained,
  output logic              txReq,
  output logic              rxReq
);
  localparam int RW    = $clog2(RUNT_BYTES);
  localparam int OCC_W = ((LVL_W > WM_W) ? LVL_W : WM_W) + 1;

  logic [WM_W-1:0]  txThr;
  logic [WM_W-1:0]  rxThr;
  logic [OCC_W-1:0] retainBytes;
  logic [OCC_W-1:0] occupied;
  logic [OCC_W-1:0] freeSpace;
  logic             txHit;
  logic             rxHit;

  assign txThr = wmBytes(txWmSel);
  assign rxThr = wmBytes(rxWmSel);

  always_comb begin
    retainBytes = strobes.txRetain ? OCC_W'(txSentBytes[RW-1:0]) : '0;
    occupied    = OCC_W'(txFifoLevel) + retainBytes;
    freeSpace   = (occupied >= OCC_W'(FIFO_DEPTH)) ? '0
                                                   : OCC_W'(FIFO_DEPTH) - occupied;
    txHit       = (freeSpace >= OCC_W'(txThr));
    rxHit       = (OCC_W'(rxFifoLevel) >= OCC_W'(rxThr));
    rxDrained   = (rxFifoLevel == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txReq <= 1'b0;
      rxReq <= 1'b0;
    end else begin
      txReq <= txHit;
      rxReq <= (strobes.rxEligible & rxHit) | (strobes.rxDonePending & ~rxDrained);
    end
  end

  AST_RX_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxReq |-> $past(strobes.rxEligible || strobes.rxDonePending)); // R6
  AST_DRAINED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rxDrained |=> !rxReq); // R9
  AST_TX_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (txFifoLevel > LVL_W'(FIFO_DEPTH - 16)) |=> !txReq); // R3

endmodule

// File: rtl/duplex_dma_request.sv
module duplex_dma_request
  import dma_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int RUNT_BYTES = 64,
  parameter int SENT_W     = 11,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fullDuplex,
  input  logic              runtAccept,
  input  logic [1:0]        txWmSel,
  input  logic [1:0]        rxWmSel,
  input  logic [LVL_W-1:0]  txFifoLevel,
  input  logic [LVL_W-1:0]  rxFifoLevel,
  input  logic              txActive,
  input  logic [SENT_W-1:0] txSentBytes,
  input  logic              rxSof,
  input  logic              rxByteIn,
  input  logic              rxFrameBad,
  input  logic              rxFrameDone,
  output logic              txReq,
  output logic              rxReq
);
  ctlStrobes_t strobes;
  logic        rxDrained;

  dma_req_ctrl #(.RUNT_BYTES(RUNT_BYTES), .SENT_W(SENT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fullDuplex(fullDuplex), .runtAccept(runtAccept),
    .rxSof(rxSof), .rxByteIn(rxByteIn), .rxFrameBad(rxFrameBad),
    .rxFrameDone(rxFrameDone), .rxDrained(rxDrained), .txActive(txActive),
    .txSentBytes(txSentBytes), .strobes(strobes)
  );

  dma_req_path #(.FIFO_DEPTH(FIFO_DEPTH), .RUNT_BYTES(RUNT_BYTES),
                 .SENT_W(SENT_W), .LVL_W(LVL_W)) u_path (
    .clk(clk), .rst_n(rst_n), .txWmSel(txWmSel), .rxWmSel(rxWmSel),
    .txFifoLevel(txFifoLevel), .rxFifoLevel(rxFifoLevel),
    .txSentBytes(txSentBytes), .strobes(strobes), .rxDrained(rxDrained),
    .txReq(txReq), .rxReq(rxReq)
  );

endmodule

// File: tb/duplex_dma_request_bench.sv
`timescale 1ns/1ps
module duplex_dma_request_bench;
  localparam int DEPTH = 512;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int SW    = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fullDuplex = 1'b0, runtAccept = 1'b0;
  logic [1:0] txWmSel = 2'd0, rxWmSel = 2'd0;
  logic [LW-1:0] txFifoLevel = '0, rxFifoLevel = '0;
  logic txActive = 1'b0;
  logic [SW-1:0] txSentBytes = '0;
  logic rxSof = 1'b0, rxByteIn = 1'b0, rxFrameBad = 1'b0, rxFrameDone = 1'b0;
  logic txReq, rxReq;

  int nChecks = 0, nFails = 0;
  string curTag = "R1";
  bit checking = 1'b0;

  int  mCount = 0;
  bit  mKilled = 0, mPend = 0, expTx = 0, expRx = 0;

  always #4 clk = ~clk;

  duplex_dma_request u_duplex_dma_request (
    .clk(clk), .rst_n(rst_n), .fullDuplex(fullDuplex), .runtAccept(runtAccept),
    .txWmSel(txWmSel), .rxWmSel(rxWmSel), .txFifoLevel(txFifoLevel),
    .rxFifoLevel(rxFifoLevel), .txActive(txActive), .txSentBytes(txSentBytes),
    .rxSof(rxSof), .rxByteIn(rxByteIn), .rxFrameBad(rxFrameBad),
    .rxFrameDone(rxFrameDone), .txReq(txReq), .rxReq(rxReq)
  );

  function automatic int thrOf(int c);
    return (c == 0) ? 16 : (64 << (c - 1));
  endfunction

  // Reference model, updated on each rising edge from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      mCount = 0; mKilled = 0; mPend = 0; expTx = 0; expRx = 0;
    end else begin
      int held, freeB;
      bit relax, gate;
      held  = (!fullDuplex && txActive && int'(txSentBytes) < 64) ? int'(txSentBytes) : 0;
      freeB = DEPTH - int'(txFifoLevel) - held;
      if (freeB < 0) freeB = 0;
      expTx = (freeB >= thrOf(int'(txWmSel)));
      relax = fullDuplex || runtAccept;
      gate  = relax || (mCount >= 64 && !mKilled);
      expRx = (gate && int'(rxFifoLevel) >= thrOf(int'(rxWmSel))) ||
              (mPend && rxFifoLevel != 0);
      if (rxFrameDone && gate) mPend = 1;
      else if (rxFifoLevel == 0) mPend = 0;
      if (rxSof) begin
        mCount = rxByteIn ? 1 : 0; mKilled = 0;
      end else begin
        if (rxFrameBad && mCount < 64) mKilled = 1;
        if (rxByteIn && mCount < 64) mCount++;
      end
    end
  end

  task automatic chk(string tag, bit act, bit exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(curTag, txReq, expTx, "txReq");
      chk(curTag, rxReq, expRx, "rxReq");
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk); #2;
      rxSof = 0; rxByteIn = 0; rxFrameBad = 0; rxFrameDone = 0;
    end
  endtask

  task automatic bytes(int n);
    repeat (n) begin rxByteIn = 1; tick(1); end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1: provocative inputs during reset
    fullDuplex = 1; rxFifoLevel = 300; txFifoLevel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", txReq, 1'b0, "txReq in reset");
    chk("R1", rxReq, 1'b0, "rxReq in reset");
    @(posedge clk); #2;
    rst_n = 1; checking = 1;
    @(negedge clk);
    chk("R1", rxReq, 1'b0, "rxReq first cycle");
    fullDuplex = 0; rxFifoLevel = 0; tick(2);

    // R3: tx threshold boundaries, all codes (R2 map)
    curTag = "R3";
    for (int c = 0; c < 4; c++) begin
      txWmSel = 2'(c);
      txFifoLevel = LW'(DEPTH - thrOf(c)); tick(2);
      txFifoLevel = LW'(DEPTH - thrOf(c) + 1); tick(2);
    end

    // R4: half-duplex retention of sent bytes
    curTag = "R4";
    txWmSel = 2'd1; txActive = 1; txFifoLevel = LW'(DEPTH - 70);
    txSentBytes = 10; tick(2);
    txSentBytes = 63; tick(2);
    txSentBytes = 64; tick(2);
    txSentBytes = 10; txActive = 0; tick(2);

    // R5: full duplex ignores retention
    curTag = "R5";
    txActive = 1; fullDuplex = 1; tick(3);
    txActive = 0;

    // R2: rx watermark codes at boundaries in full duplex
    curTag = "R2";
    for (int c = 0; c < 4; c++) begin
      rxWmSel = 2'(c);
      rxFifoLevel = LW'(thrOf(c) - 1); tick(2);
      rxFifoLevel = LW'(thrOf(c)); tick(2);
    end

    // R7: short frame in full duplex, watermark alone
    curTag = "R7";
    rxWmSel = 2'd0; rxFifoLevel = 0; tick(1);
    rxSof = 1; tick(1); bytes(5);
    rxFifoLevel = 16; tick(3);

    // R6: half duplex 64-byte gate
    curTag = "R6";
    fullDuplex = 0; rxFifoLevel = 0; tick(2);
    rxSof = 1; rxByteIn = 1; tick(1);
    bytes(62);
    rxFifoLevel = 200; tick(3);
    bytes(1); tick(3);

    // R10: new frame closes the gate
    curTag = "R10";
    rxSof = 1; tick(1); tick(3);

    // R8: runt override equals full duplex
    curTag = "R8";
    runtAccept = 1; tick(3);
    runtAccept = 0; tick(2);

    // R11: early bad kills, late bad ignored
    curTag = "R11";
    rxSof = 1; tick(1); bytes(10);
    rxFrameBad = 1; tick(1); bytes(60); tick(3);
    rxSof = 1; tick(1); bytes(70);
    rxFrameBad = 1; tick(1); tick(3);

    // R9: frame-complete request until drained
    curTag = "R9";
    rxFifoLevel = 0; tick(2);
    rxSof = 1; tick(1); bytes(70);
    rxFifoLevel = 5; rxFrameDone = 1; tick(1); tick(3);
    rxFifoLevel = 0; tick(3);
    rxSof = 1; tick(1); bytes(20);
    rxFifoLevel = 5; rxFrameDone = 1; tick(1); tick(3);
    rxFifoLevel = 0; tick(2);
    fullDuplex = 1;
    rxSof = 1; tick(1); bytes(20);
    rxFifoLevel = 5; rxFrameDone = 1; tick(1); tick(3);
    rxFifoLevel = 0; tick(3);

    checking = 0;
    report();
  end

endmodule